// File: doc/BRIEF.md
# Multiphase Burst-Dimming PWM Generator

This block drives up to twelve lamp-dimming PWM lanes from one dimming code. Every active lane has the same period and the same high time. Lane k is shifted in time by k steps, and one step is the PWM period divided by the number of active lanes, rounded down. The lanes are therefore spread evenly across each period, so the lamps never switch together. The PWM period is half the timebase period, which makes the burst rate twice the timebase rate.

The timebase is measured from an external vertical-sync input, counted in clock cycles between rising edges. If no rising edge arrives within a timeout, the block switches to a fixed internal timebase period. A 2-bit selector sets how many lanes are active. A polarity input chooses whether a larger dimming code gives a longer or a shorter high time. Every lane has a data bit and an output-enable bit, which together form a three-state driver. Lanes that are not selected, and every lane while the block is disabled, have the enable low. New settings and a newly measured period take effect only at a period boundary, so no lane is cut short.

Top module: `mpd_dimmer`

## Requirements
- R1: During and directly after reset, `lamp_oe` and `lamp_d` are all zero.
- R2: With `en` low, every `lamp_oe` bit is zero from the next clock cycle on, and `lamp_d` is zero. When `en` returns high, output starts again with lane 0 at phase 0.
- R3: The number of active lanes n depends on `sel`: 2'b00 gives 6, 2'b01 gives 8, 2'b10 gives 10 and 2'b11 gives 12. Lanes 0 to n-1 have `lamp_oe` high. Every other lane has `lamp_oe` low and `lamp_d` zero.
- R4: If no sync has been accepted, the PWM period is INT_PER/2 clock cycles (rounded down).
- R5: Once two `vsync` rising edges have arrived less than TMO_CYC cycles apart, the PWM period is floor(P/2), where P is the number of cycles between those edges.
- R6: If no `vsync` rising edge arrives for TMO_CYC cycles, the sync is dropped and the period returns to INT_PER/2.
- R7: With `pol` high, every active lane is high for on = floor(duty·per/2^DW) cycles of each period.
- R8: With `pol` low, every active lane is low for those on cycles and high for the remaining per−on cycles.
- R9: Lane k reaches its own phase 0 exactly k·floor(per/n) cycles after lane 0 reaches phase 0.
- R10: Changes to `duty`, `sel`, `pol` or the measured period are applied only at the end of a PWM period. A period that has already started runs to its end with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Block enable |
| vsync | input | 1 | External sync; rising edges set the timebase |
| sel | input | 2 | Active lane count code |
| pol | input | 1 | Polarity: 1 means a larger code gives a longer high time |
| duty | input | DW | Dimming code |
| lamp_d | output | NL | Lane data bits |
| lamp_oe | output | NL | Lane output enables (0 = high impedance) |

## Verification
The bench locks onto the moment lane 0 starts a period and then compares every active lane on every cycle of that period against a model of width, polarity and phase step. A wrong step, wrong rounding or an off-by-one in the phase compare therefore shows up as a mismatch on a shifted lane. It changes the dimming code halfway through a period. A design that applied the change at once would show a wrong high time in that same period. It moves between three sync rates, removes the sync, and checks that the period follows the halved rate and then falls back to the internal period. A design with the factor of two missing, or with no timeout, would keep the wrong period. It also covers each selector code and both polarities.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

  // Active lane count from the 2-bit selector: 6, 8, 10, 12.
  function automatic logic [3:0] lane_count(input logic [1:0] sel);
    return 4'd6 + {1'b0, sel, 1'b0};
  endfunction

  // Position of a lane inside the period, given the shared phase and its offset.
  function automatic int unsigned lane_pos(input int unsigned ph,
                                           input int unsigned off,
                                           input int unsigned per);
    if (ph >= off) return ph - off;
    return ph + per - off;
  endfunction

  // Lane level for a position: lit while pos < on, inverted when pol is low.
  function automatic logic lane_level(input int unsigned pos,
                                      input int unsigned on,
                                      input logic pol);
    return (pos < on) ~^ pol;
  endfunction

endpackage

// File: rtl/mpd_sync_meter.sv
module mpd_sync_meter #(
  parameter int CW  = 15,
  parameter int TMO = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync_i,
  output logic          edge_o,
  output logic [CW-1:0] gap_o,
  output logic          sync_ok_o,
  output logic [CW-1:0] tb_per_o
);
  localparam logic [CW-1:0] GAP_MAX = CW'(TMO - 1);

  logic [2:0] sy;
  logic       have_ref;
  logic       tmo_hit;

  assign edge_o  = sy[1] & ~sy[2];
  assign tmo_hit = !edge_o && (gap_o == GAP_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy        <= '0;
      gap_o     <= '0;
      have_ref  <= 1'b0;
      sync_ok_o <= 1'b0;
      tb_per_o  <= '0;
    end else begin
      sy <= {sy[1:0], vsync_i};
      if (edge_o) begin
        gap_o    <= '0;
        have_ref <= 1'b1;
        if (have_ref) begin
          tb_per_o  <= gap_o + CW'(1);
          sync_ok_o <= 1'b1;
        end
      end else if (tmo_hit) begin
        have_ref  <= 1'b0;
        sync_ok_o <= 1'b0;
      end else begin
        gap_o <= gap_o + CW'(1);
      end
    end
  end
endmodule

// File: rtl/mpd_frame.sv
module mpd_frame
  import mpd_pkg::*;
#(
  parameter int CW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] pend_per,
  input  logic [DW-1:0] duty,
  input  logic [1:0]    sel,
  input  logic          pol,
  output logic          run,
  output logic          bnd,
  output logic [CW-1:0] ph,
  output logic [CW-1:0] per_q,
  output logic [CW-1:0] on_q,
  output logic [CW-1:0] step_q,
  output logic [3:0]    nph_q,
  output logic          pol_q
);
  localparam int PW = CW + DW;

  logic [PW-1:0] prod;
  logic [CW-1:0] on_n;
  logic [CW-1:0] step_n;
  logic [3:0]    nph_n;

  always_comb begin
    nph_n  = lane_count(sel);
    prod   = PW'(duty) * PW'(pend_per);
    on_n   = CW'(prod >> DW);
    step_n = pend_per / CW'(nph_n);
  end

  assign bnd = !run || (ph == per_q - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      ph     <= '0;
      per_q  <= CW'(2);
      on_q   <= '0;
      step_q <= '0;
      nph_q  <= 4'd6;
      pol_q  <= 1'b1;
    end else begin
      run <= en;
      if (!en) begin
        ph <= '0;
      end else if (bnd) begin
        ph     <= '0;
        per_q  <= pend_per;
        on_q   <= on_n;
        step_q <= step_n;
        nph_q  <= nph_n;
        pol_q  <= pol;
      end else begin
        ph <= ph + CW'(1);
      end
    end
  end
endmodule

// File: rtl/mpd_lane.sv
module mpd_lane
  import mpd_pkg::*;
#(
  parameter int CW  = 15,
  parameter int IDX = 0
) (
  input  logic          run,
  input  logic [CW-1:0] ph,
  input  logic [CW-1:0] per_q,
  input  logic [CW-1:0] on_q,
  input  logic [CW-1:0] step_q,
  input  logic [3:0]    nph_q,
  input  logic          pol_q,
  output logic          d,
  output logic          oe
);
  logic [CW-1:0] off;
  logic [CW-1:0] pos;

  always_comb begin
    off = CW'(IDX) * step_q;
    pos = CW'(lane_pos(32'(ph), 32'(off), 32'(per_q)));
    oe  = run && (4'(IDX) < nph_q);
    d   = oe && lane_level(32'(pos), 32'(on_q), pol_q);
  end
endmodule

// File: rtl/mpd_dimmer.sv
module mpd_dimmer #(
  parameter int NL      = 12,
  parameter int DW      = 8,
  parameter int CW      = 15,
  parameter int INT_PER = 8333,
  parameter int TMO_CYC = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          vsync,
  input  logic [1:0]    sel,
  input  logic          pol,
  input  logic [DW-1:0] duty,
  output logic [NL-1:0] lamp_d,
  output logic [NL-1:0] lamp_oe
);
  localparam logic [CW-1:0] INT_TB  = CW'(INT_PER);
  localparam logic [CW-1:0] MIN_PER = CW'(2);

  logic          vs_edge;
  logic [CW-1:0] gap;
  logic          sync_ok;
  logic [CW-1:0] tb_per;
  logic [CW-1:0] tb_sel;
  logic [CW-1:0] half;
  logic [CW-1:0] pend_per;

  logic          run;
  logic          bnd;
  logic [CW-1:0] ph;
  logic [CW-1:0] per_q;
  logic [CW-1:0] on_q;
  logic [CW-1:0] step_q;
  logic [3:0]    nph_q;
  logic          pol_q;

  mpd_sync_meter #(.CW(CW), .TMO(TMO_CYC)) u_meter (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync),
    .edge_o(vs_edge), .gap_o(gap), .sync_ok_o(sync_ok), .tb_per_o(tb_per)
  );

  always_comb begin
    tb_sel   = sync_ok ? tb_per : INT_TB;
    half     = tb_sel >> 1;
    pend_per = (half < MIN_PER) ? MIN_PER : half;
  end

  mpd_frame #(.CW(CW), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(en), .pend_per(pend_per),
    .duty(duty), .sel(sel), .pol(pol),
    .run(run), .bnd(bnd), .ph(ph), .per_q(per_q), .on_q(on_q),
    .step_q(step_q), .nph_q(nph_q), .pol_q(pol_q)
  );

  for (genvar k = 0; k < NL; k++) begin : g_lane
    mpd_lane #(.CW(CW), .IDX(k)) u_lane (
      .run(run), .ph(ph), .per_q(per_q), .on_q(on_q), .step_q(step_q),
      .nph_q(nph_q), .pol_q(pol_q), .d(lamp_d[k]), .oe(lamp_oe[k])
    );
  end
endmodule

// File: rtl/mpd_checker.sv
module mpd_checker #(
  parameter int CW  = 15,
  parameter int NL  = 12,
  parameter int TMO = 20000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [NL-1:0] lamp_d,
  input logic [NL-1:0] lamp_oe,
  input logic          bnd,
  input logic [CW-1:0] ph,
  input logic [CW-1:0] per_q,
  input logic [CW-1:0] gap,
  input logic          sync_ok,
  input logic          vs_edge
);
  // R2: disabled block floats every lane one cycle later
  p_hiz_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (lamp_oe == '0 && lamp_d == '0));

  // R3: active lanes always form a low-order prefix
  p_lane_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_oe & (lamp_oe + NL'(1))) == '0);

  // R3: active count is one of the selectable values
  p_lane_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_oe == '0 || $countones(lamp_oe) inside {6, 8, 10, 12});

  // R10: latched period is held except across a boundary
  p_hold_mid_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(per_q));

  // R10: shared phase never leaves the current period
  p_phase_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ph < per_q);

  // R6: sync is dropped only after the full silent window
  p_drop_on_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_ok) |-> $past(gap) == CW'(TMO - 1));

  // R5: sync is accepted only on a rising edge
  p_lock_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $past(vs_edge));
endmodule

bind mpd_dimmer mpd_checker #(.CW(CW), .NL(NL), .TMO(TMO_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .lamp_d(lamp_d), .lamp_oe(lamp_oe),
  .bnd(bnd), .ph(ph), .per_q(per_q), .gap(gap), .sync_ok(sync_ok),
  .vs_edge(vs_edge)
);

// File: tb/sim_mpd_dimmer.sv
module sim_mpd_dimmer;
  localparam int CLK_P = 10;
  localparam int NL    = 12;
  localparam int DW    = 8;
  localparam int CW    = 12;
  localparam int INTP  = 400;
  localparam int TMO   = 1200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          vsync = 1'b0;
  logic [1:0]    sel = 2'b11;
  logic          pol = 1'b1;
  logic [DW-1:0] duty = 8'd128;
  logic [NL-1:0] lamp_d;
  logic [NL-1:0] lamp_oe;

  int n_chk = 0;
  int n_bad = 0;
  int vs_per = 0;

  always #(CLK_P/2) clk = ~clk;

  mpd_dimmer #(.NL(NL), .DW(DW), .CW(CW), .INT_PER(INTP), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .vsync(vsync), .sel(sel),
    .pol(pol), .duty(duty), .lamp_d(lamp_d), .lamp_oe(lamp_oe)
  );

  // sync source: vs_per cycles per pulse, 0 means absent
  initial begin
    forever begin
      if (vs_per == 0) begin
        @(negedge clk);
      end else begin
        int p;
        p = vs_per;
        vsync = 1'b1;
        repeat (4) @(negedge clk);
        vsync = 1'b0;
        repeat (p - 4) @(negedge clk);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nlanes(input logic [1:0] s);
    return 6 + 2 * int'(s);
  endfunction

  function automatic bit exp_bit(input int t, input int k, input int per,
                                 input int n, input int dcode, input bit pl);
    int on, off, pos;
    on  = (dcode * per) / (1 << DW);
    off = k * (per / n);
    pos = (t - off + per) % per;
    return (pos < on) ? pl : !pl;
  endfunction

  // wait for lane 0 to enter its phase-0 level; returns with t=0 sampled
  task automatic align(input bit pl, output bit ok);
    logic prev;
    ok = 1'b0;
    @(negedge clk);
    prev = lamp_d[0];
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (lamp_d[0] != prev && lamp_d[0] == pl) begin
        ok = 1'b1;
        break;
      end
      prev = lamp_d[0];
    end
  endtask

  task automatic measure(input bit pl, input int exp, input string tag);
    bit ok;
    int cnt;
    logic prev;
    align(pl, ok);
    prev = lamp_d[0];
    cnt = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cnt++;
      if (lamp_d[0] != prev && lamp_d[0] == pl) break;
      prev = lamp_d[0];
    end
    chk(ok && cnt == exp, tag, cnt, exp);
  endtask

  // compare all lanes over one period; optionally change duty halfway
  task automatic cmp_period(input int per, input int dcode, input bit mid_chg,
                            input logic [DW-1:0] dnew, input string tag);
    bit ok;
    int n;
    int err [NL];
    n = nlanes(sel);
    for (int k = 0; k < NL; k++) err[k] = 0;
    align(pol, ok);
    chk(ok, {tag, " align"}, int'(ok), 1);
    chk(lamp_oe == NL'((1 << n) - 1), "R3 enable mask", int'(lamp_oe), (1 << n) - 1);
    for (int t = 0; t < per; t++) begin
      if (t > 0) @(negedge clk);
      if (mid_chg && t == per / 2) duty = dnew;
      for (int k = 0; k < NL; k++) begin
        if (k < n) begin
          if (lamp_d[k] != exp_bit(t, k, per, n, dcode, pol)) err[k]++;
        end else if (lamp_d[k] != 1'b0 || lamp_oe[k] != 1'b0) begin
          err[k]++;
        end
      end
    end
    for (int k = 0; k < NL; k++)
      chk(err[k] == 0, $sformatf("%s lane %0d mismatches", tag, k), err[k], 0);
  endtask

  initial begin
    #(CLK_P * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int cur_vs;
    int per;
    void'($urandom(32'd4242));

    // R1: reset state
    repeat (4) @(negedge clk);
    chk(lamp_oe == '0 && lamp_d == '0, "R1 reset outputs", int'(lamp_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lamp_oe == '0 && lamp_d == '0, "R1 after reset", int'(lamp_oe), 0);

    // R4: internal timebase
    en = 1'b1;
    repeat (3 * INTP) @(negedge clk);
    measure(1'b1, INTP / 2, "R4 internal period");
    cmp_period(INTP / 2, 128, 1'b0, '0, "R7 R9 sel3 internal");

    // R3: every selector code
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      repeat (INTP) @(negedge clk);
      chk($countones(lamp_oe) == nlanes(sel), "R3 lane count",
          $countones(lamp_oe), nlanes(sel));
      cmp_period(INTP / 2, 128, 1'b0, '0, "R3 R9 sel sweep");
    end

    // R8: inverted polarity
    pol = 1'b0;
    duty = 8'd60;
    repeat (INTP) @(negedge clk);
    cmp_period(INTP / 2, 60, 1'b0, '0, "R8 low polarity");
    pol = 1'b1;

    // R5: external sync locks and halves
    vs_per = 300;
    repeat (3 * 300 + INTP) @(negedge clk);
    measure(1'b1, 150, "R5 sync 300");
    cmp_period(150, 60, 1'b0, '0, "R5 R7 sync 300");

    // R10: mid-period duty change waits for the boundary
    cmp_period(150, 60, 1'b1, 8'd200, "R10 old duty holds");
    cmp_period(150, 200, 1'b0, '0, "R10 new duty applied");

    // random mix
    cur_vs = 300;
    for (int it = 0; it < 14; it++) begin
      int pick;
      int nv;
      pick = int'($urandom_range(0, 3));
      nv = (pick == 0) ? 0 : (pick == 1) ? 300 : (pick == 2) ? 520 : 1000;
      sel  = 2'($urandom_range(0, 3));
      pol  = 1'($urandom_range(0, 1));
      duty = DW'($urandom_range(8, 247));
      if (nv != cur_vs) begin
        vs_per = nv;
        repeat (3 * 1000 + 1000 + ((nv == 0) ? TMO : 0)) @(negedge clk);
        cur_vs = nv;
      end else begin
        repeat (1100) @(negedge clk);
      end
      per = (cur_vs == 0) ? INTP / 2 : cur_vs / 2;
      cmp_period(per, int'(duty), 1'b0, '0,
                 (cur_vs == 0) ? "R4 R7 R8 R9 random" : "R5 R7 R8 R9 random");
    end

    // R6: sync removed, internal period returns
    pol = 1'b1;
    duty = 8'd100;
    vs_per = 520;
    repeat (4 * 520 + 600) @(negedge clk);
    measure(1'b1, 260, "R5 sync 520");
    vs_per = 0;
    repeat (TMO + 3 * INTP) @(negedge clk);
    measure(1'b1, INTP / 2, "R6 timeout fallback");

    // R2: disable floats all lanes, enable restarts
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(lamp_oe == '0 && lamp_d == '0, "R2 disabled floats", int'(lamp_oe), 0);
    repeat (50) @(negedge clk);
    chk(lamp_oe == '0, "R2 still floating", int'(lamp_oe), 0);
    en = 1'b1;
    @(negedge clk);
    chk(lamp_oe == NL'((1 << nlanes(sel)) - 1) && lamp_d[0] == 1'b1,
        "R2 restart at phase 0", int'(lamp_oe), (1 << nlanes(sel)) - 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule